// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a list of memory segments into the physical region descriptor table that a bus-master disk DMA engine walks. A requester streams segments in, each one a start address and a byte length, and marks the final one. The block cuts every segment at 64 KB address boundaries and emits one 8-byte descriptor per piece, in order, on a valid/ready output stream. The last descriptor of the table carries an end-of-table flag.

Some engines read a count field of zero as zero bytes instead of 64 KB. To stay safe, a piece that would fill a whole 64 KB window is never emitted as one descriptor. It goes out as two 32 KB descriptors instead.

Once a table closes, the block reports a status code. If the table would exceed its configured size, or no descriptor came out, or a segment breaks the selected alignment rule, the code tells the requester to fall back to programmed I/O.

Because the end flag can only be placed once the last segment has been seen, the block always keeps one descriptor back in a holding register. It releases that descriptor when a successor exists or when the table is finished.

Top module: `prd_table_gen`

## Requirements
- R1: Within a segment, every piece starts at the current address and is min(0x10000 − address[15:0], bytes remaining) long, so no descriptor spans a 64 KB address boundary. Descriptors come out in segment order and address order.
- R2: The descriptor is desc_data[63:0]. Bits [31:0] hold the piece start address. Bits [47:32] hold the piece length modulo 65536. Bits [62:48] are zero.
- R3: A piece of exactly 0x10000 bytes is emitted as two descriptors: count 0x8000 at the piece address, then count 0x8000 at that address + 0x8000.
- R4: desc_data[63] is 1 only on the final descriptor of a table that closes normally. After that descriptor is accepted, done_valid pulses with done_status = 0 (success).
- R5: A segment of length zero produces no descriptor and does not disturb the end flag placement.
- R6: If a table needs more than MAX_DESC descriptors, the block aborts. In that case exactly MAX_DESC − 1 descriptors have been emitted, none of them with bit 63 set, and done_status = 1 (overflow).
- R7: A table that closes with no descriptor at all reports done_status = 2 (empty).
- R8: With align_word = 0, the address and length of every segment must be even. With align_word = 1, both must be multiples of 4. A violating segment aborts the table with done_status = 3 (misaligned); the held descriptor is discarded and no end flag is emitted.
- R9: After an abort, input segments are accepted and discarded up to and including the one marked seg_last, and only then is done reported. The next table starts with an empty descriptor count.
- R10: While desc_valid is high and desc_ready is low, desc_valid stays high and desc_data stays unchanged, and no descriptor is lost.
- R11: During and right after reset, desc_valid and done_valid are low and seg_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| align_word | input | 1 | 0: 2-byte alignment rule, 1: 4-byte alignment rule; sampled with each segment |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted this cycle when seg_valid is also high |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Marks the final segment of a table |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Downstream takes the descriptor |
| desc_data | output | 64 | Descriptor: address [31:0], count [47:32], end flag [63] |
| done_valid | output | 1 | One-cycle pulse when a table closes |
| done_status | output | 2 | 0 success, 1 overflow, 2 empty, 3 misaligned; valid with done_valid |

## Verification
The bench builds the block with MAX_DESC = 6 and LEN_W = 20. A six-entry table can be hit exactly by a 192 KB segment and overrun by a 448 KB one, so both the fit case and the overflow path are reached in a few dozen cycles. The 20-bit length allows segments covering several whole 64 KB windows, which exercises the repeated halving of full windows together with the abort and drain sequence. Every vector is run once with a free output and once with a pseudo-random stall on desc_ready.

// File: rtl/prd_pkg.sv
`timescale 1ns/1ps
package prd_pkg;

    localparam int          PRD_ADDR_W = 32;
    localparam logic [16:0] PRD_WINDOW = 17'h10000;
    localparam logic [15:0] PRD_HALF   = 16'h8000;

    typedef enum logic [1:0] {
        TBL_OK       = 2'd0,
        TBL_OVERFLOW = 2'd1,
        TBL_EMPTY    = 2'd2,
        TBL_MISALIGN = 2'd3
    } tbl_status_e;

    typedef enum logic [1:0] {
        GEN_COLLECT = 2'd0,
        GEN_FLUSH   = 2'd1,
        GEN_DRAIN   = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic [PRD_ADDR_W-1:0] addr;
        logic [15:0]           count;
    } prd_chunk_t;

    // Build the 64-bit descriptor word from a piece and the end flag.
    function automatic logic [63:0] prd_pack(input prd_chunk_t c, input logic eot);
        return {eot, 15'd0, c.count, c.addr};
    endfunction

    // Alignment rule: low bit (2-byte mode) or low two bits (4-byte mode).
    function automatic logic prd_misaligned(input logic [1:0] a_lo,
                                            input logic [1:0] l_lo,
                                            input logic       wide);
        logic [1:0] mask;
        mask = wide ? 2'b11 : 2'b01;
        return |((a_lo | l_lo) & mask);
    endfunction

endpackage

// File: rtl/prd_chunker.sv
`timescale 1ns/1ps
module prd_chunker
    import prd_pkg::*;
#(
    parameter int LEN_W = 24
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [PRD_ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]      load_len,
    input  logic                  kill,
    input  logic                  take,
    output logic                  busy,
    output prd_chunk_t            chunk
);

    localparam logic [LEN_W-1:0] FULL_L = LEN_W'(PRD_WINDOW);
    localparam logic [LEN_W-1:0] HALF_L = LEN_W'(PRD_HALF);

    logic [PRD_ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]      rem;
    logic [LEN_W-1:0]      room;
    logic [LEN_W-1:0]      fit;
    logic [LEN_W-1:0]      step;
    logic                  busy_q;

    // Bytes left in the current 64 KB window, clipped to what remains;
    // a whole window is shortened to its first half, the second half
    // then falls out naturally on the next step.
    always_comb begin
        room = LEN_W'(PRD_WINDOW - {1'b0, cur_addr[15:0]});
        fit  = (rem < room) ? rem : room;
        step = (fit == FULL_L) ? HALF_L : fit;
    end

    assign busy        = busy_q;
    assign chunk.addr  = cur_addr;
    assign chunk.count = step[15:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            cur_addr <= '0;
            rem      <= '0;
        end else if (kill) begin
            busy_q   <= 1'b0;
        end else if (load) begin
            busy_q   <= (load_len != '0);
            cur_addr <= load_addr;
            rem      <= load_len;
        end else if (busy_q && take) begin
            cur_addr <= cur_addr + PRD_ADDR_W'(step);
            rem      <= rem - step;
            if (rem == step) busy_q <= 1'b0;
        end
    end

    // R1: a piece never runs past the end of its 64 KB window
    assert_no_cross_R1: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (({1'b0, chunk.addr[15:0]} + {1'b0, chunk.count}) <= PRD_WINDOW));

    // R3: the count field handed downstream is never zero
    assert_nonzero_count_R3: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (chunk.count != 16'd0));

endmodule

// File: rtl/prd_slot.sv
`timescale 1ns/1ps
module prd_slot
    import prd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       drop,
    input  logic       fill,
    input  prd_chunk_t fill_data,
    input  logic       pop,
    output logic       full,
    output prd_chunk_t data
);

    always_ff @(posedge clk) begin
        if (rst || drop) begin
            full <= 1'b0;
            data <= '0;
        end else if (fill) begin
            full <= 1'b1;
            data <= fill_data;
        end else if (pop) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/prd_ctrl.sv
`timescale 1ns/1ps
module prd_ctrl
    import prd_pkg::*;
#(
    parameter int MAX_DESC = 256
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        seg_valid,
    input  logic        seg_last,
    input  logic        seg_bad,
    input  logic        chunk_busy,
    input  logic        slot_full,
    input  logic        desc_ready,
    output logic        seg_ready,
    output logic        load,
    output logic        kill,
    output logic        take,
    output logic        pop,
    output logic        desc_valid,
    output logic        desc_end,
    output logic        done_valid,
    output tbl_status_e done_status
);

    localparam int CNT_W = $clog2(MAX_DESC + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_DESC);

    gen_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             last_seen;
    tbl_status_e      cause;

    logic collect, cap_hit, seg_fire, bad_seg, over, abort, finish_now;

    always_comb begin
        collect    = (state == GEN_COLLECT);
        cap_hit    = (cnt == CAP);
        seg_ready  = (collect && !chunk_busy && !last_seen) || (state == GEN_DRAIN);
        seg_fire   = seg_valid && seg_ready;
        bad_seg    = collect && seg_fire && seg_bad;
        load       = collect && seg_fire && !seg_bad;
        over       = collect && chunk_busy && cap_hit;
        abort      = bad_seg || over;
        kill       = over;
        finish_now = collect && last_seen && !chunk_busy;
        take       = collect && chunk_busy && !cap_hit && (!slot_full || desc_ready);
        desc_valid = slot_full && ((collect && chunk_busy && !cap_hit) || (state == GEN_FLUSH));
        desc_end   = (state == GEN_FLUSH);
        pop        = (state == GEN_FLUSH) && desc_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= GEN_COLLECT;
            cnt         <= '0;
            last_seen   <= 1'b0;
            cause       <= TBL_OK;
            done_valid  <= 1'b0;
            done_status <= TBL_OK;
        end else begin
            done_valid <= 1'b0;
            unique case (state)
                GEN_COLLECT: begin
                    if (abort) begin
                        cnt <= '0;
                        if (bad_seg ? seg_last : last_seen) begin
                            done_valid  <= 1'b1;
                            done_status <= bad_seg ? TBL_MISALIGN : TBL_OVERFLOW;
                            last_seen   <= 1'b0;
                        end else begin
                            state <= GEN_DRAIN;
                            cause <= bad_seg ? TBL_MISALIGN : TBL_OVERFLOW;
                        end
                    end else if (finish_now) begin
                        last_seen <= 1'b0;
                        if (slot_full) begin
                            state <= GEN_FLUSH;
                        end else begin
                            done_valid  <= 1'b1;
                            done_status <= TBL_EMPTY;
                            cnt         <= '0;
                        end
                    end else begin
                        if (load && seg_last) last_seen <= 1'b1;
                        if (take) cnt <= cnt + CNT_W'(1);
                    end
                end
                GEN_FLUSH: begin
                    if (desc_ready) begin
                        done_valid  <= 1'b1;
                        done_status <= TBL_OK;
                        cnt         <= '0;
                        state       <= GEN_COLLECT;
                    end
                end
                GEN_DRAIN: begin
                    if (seg_valid && seg_last) begin
                        done_valid  <= 1'b1;
                        done_status <= cause;
                        state       <= GEN_COLLECT;
                    end
                end
                default: state <= GEN_COLLECT;
            endcase
        end
    end

    // R6: the descriptor count never passes the table size
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CAP);

    // R4: handing over the flagged descriptor closes the table successfully
    assert_end_closes_ok_R4: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_end && desc_ready) |=> (done_valid && done_status == TBL_OK));

    // R9: the marked segment ends a drain with a failure report
    assert_drain_reports_R9: assert property (@(posedge clk) disable iff (rst)
        (state == GEN_DRAIN && seg_valid && seg_last) |=> (done_valid && done_status != TBL_OK));

endmodule

// File: rtl/prd_table_gen.sv
`timescale 1ns/1ps
module prd_table_gen
    import prd_pkg::*;
#(
    parameter int LEN_W    = 24,
    parameter int MAX_DESC = 256
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             align_word,
    input  logic             seg_valid,
    output logic             seg_ready,
    input  logic [31:0]      seg_addr,
    input  logic [LEN_W-1:0] seg_len,
    input  logic             seg_last,
    output logic             desc_valid,
    input  logic             desc_ready,
    output logic [63:0]      desc_data,
    output logic             done_valid,
    output logic [1:0]       done_status
);

    logic        seg_bad;
    logic        load, kill, take, pop, desc_end;
    logic        chunk_busy, slot_full;
    prd_chunk_t  chunk, slot_data;
    tbl_status_e status_w;

    assign seg_bad = prd_misaligned(seg_addr[1:0], seg_len[1:0], align_word);

    prd_chunker #(.LEN_W(LEN_W)) u_chunker (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (seg_addr),
        .load_len  (seg_len),
        .kill      (kill),
        .take      (take),
        .busy      (chunk_busy),
        .chunk     (chunk)
    );

    prd_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .drop      (kill | (load & 1'b0) | (seg_valid & seg_ready & seg_bad & ~chunk_busy)),
        .fill      (take),
        .fill_data (chunk),
        .pop       (pop),
        .full      (slot_full),
        .data      (slot_data)
    );

    prd_ctrl #(.MAX_DESC(MAX_DESC)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .seg_valid   (seg_valid),
        .seg_last    (seg_last),
        .seg_bad     (seg_bad),
        .chunk_busy  (chunk_busy),
        .slot_full   (slot_full),
        .desc_ready  (desc_ready),
        .seg_ready   (seg_ready),
        .load        (load),
        .kill        (kill),
        .take        (take),
        .pop         (pop),
        .desc_valid  (desc_valid),
        .desc_end    (desc_end),
        .done_valid  (done_valid),
        .done_status (status_w)
    );

    assign desc_data   = prd_pack(slot_data, desc_end);
    assign done_status = status_w;

    // R10: an offered descriptor is held steady until taken
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_data)));

    // R10: a new piece only enters the holding register when the old one leaves
    assert_no_loss_R10: assert property (@(posedge clk) disable iff (rst)
        (take && slot_full) |-> (desc_valid && desc_ready));

    // R5: a zero-length segment leaves the splitter idle
    assert_zero_len_R5: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && seg_ready && seg_len == '0) |=> !chunk_busy);

endmodule

// File: tb/sim_prd_table_gen.sv
`timescale 1ns/1ps
module sim_prd_table_gen;

    localparam int LEN_W    = 20;
    localparam int MAX_DESC = 6;
    localparam int NVEC     = 15;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             align_word = 1'b0;
    logic             seg_valid = 1'b0;
    logic             seg_ready;
    logic [31:0]      seg_addr = '0;
    logic [LEN_W-1:0] seg_len = '0;
    logic             seg_last = 1'b0;
    logic             desc_valid;
    logic             desc_ready = 1'b1;
    logic [63:0]      desc_data;
    logic             done_valid;
    logic [1:0]       done_status;

    always #10 clk = ~clk;

    prd_table_gen #(.LEN_W(LEN_W), .MAX_DESC(MAX_DESC)) u0 (
        .clk(clk), .rst(rst), .align_word(align_word),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
        .done_valid(done_valid), .done_status(done_status)
    );

    // Output-side stall pattern
    logic       stall = 1'b0;
    logic       force_low = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    always @(posedge clk) begin
        lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        desc_ready <= force_low ? 1'b0 : (stall ? (lfsr[0] | lfsr[2]) : 1'b1);
    end

    // Monitor: record every accepted descriptor and every done pulse
    logic [63:0] cap [0:255];
    int          cap_n = 0;
    int          done_cnt = 0;
    logic [1:0]  got_status = 2'd0;
    always @(negedge clk) begin
        if (desc_valid && desc_ready) begin
            cap[cap_n % 256] = desc_data;
            cap_n = cap_n + 1;
        end
        if (done_valid) begin
            got_status = done_status;
            done_cnt   = done_cnt + 1;
        end
    end

    int errors = 0;
    int total  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Stimulus table: one table of one or two segments per entry
    typedef struct packed {
        logic [31:0] a0;
        logic [23:0] l0;
        logic [31:0] a1;
        logic [23:0] l1;
        logic        two;
        logic        al4;
        logic [1:0]  st;
        logic [7:0]  nd;
    } vec_t;

    localparam vec_t VECS [0:NVEC-1] = '{
        '{32'h0001_2000, 24'h01000, 32'h0, 24'h0,     1'b0, 1'b0, 2'd0, 8'd1},
        '{32'h0000_F000, 24'h03000, 32'h0, 24'h0,     1'b0, 1'b0, 2'd0, 8'd2},
        '{32'h0002_0000, 24'h10000, 32'h0, 24'h0,     1'b0, 1'b0, 2'd0, 8'd2},
        '{32'h0003_0000, 24'h18000, 32'h0, 24'h0,     1'b0, 1'b0, 2'd0, 8'd3},
        '{32'h0004_FFFE, 24'h00004, 32'h0, 24'h0,     1'b0, 1'b0, 2'd0, 8'd2},
        '{32'h0000_1000, 24'h00100, 32'h2000, 24'h0,  1'b1, 1'b0, 2'd0, 8'd1},
        '{32'h0000_8000, 24'h00000, 32'h9000, 24'h0,  1'b1, 1'b0, 2'd2, 8'd0},
        '{32'h0000_6002, 24'h00010, 32'h0, 24'h0,     1'b0, 1'b1, 2'd3, 8'd0},
        '{32'h0000_6002, 24'h00010, 32'h0, 24'h0,     1'b0, 1'b0, 2'd0, 8'd1},
        '{32'h0000_7001, 24'h00002, 32'h0, 24'h0,     1'b0, 1'b0, 2'd3, 8'd0},
        '{32'h0000_0000, 24'h70000, 32'h100, 24'h10,  1'b1, 1'b0, 2'd1, 8'd5},
        '{32'h0000_0000, 24'h30000, 32'h0, 24'h0,     1'b0, 1'b0, 2'd0, 8'd6},
        '{32'h0001_FF00, 24'h00200, 32'h90000, 24'h20,1'b1, 1'b0, 2'd0, 8'd3},
        '{32'h0000_0100, 24'h00006, 32'h0, 24'h0,     1'b0, 1'b1, 2'd3, 8'd0},
        '{32'h0000_1000, 24'h00010, 32'h3002, 24'h8,  1'b1, 1'b1, 2'd3, 8'd0}
    };

    // Expected descriptor list built from R1 and R3
    logic [31:0] exp_a [0:31];
    logic [15:0] exp_c [0:31];
    int          exp_n;

    task automatic push_exp(input longint a, input longint c);
        if (exp_n < 32) begin
            exp_a[exp_n] = a[31:0];
            exp_c[exp_n] = c[15:0];
        end
        exp_n++;
    endtask

    task automatic model_seg(input logic [31:0] a, input logic [23:0] l);
        longint cur;
        longint left;
        cur  = longint'(a);
        left = longint'(l);
        while (left > 0) begin
            longint room;
            longint n;
            room = 64'h10000 - (cur % 64'h10000);
            n    = (left < room) ? left : room;
            if (n == 64'h10000) begin
                push_exp(cur, 64'h8000);
                push_exp(cur + 64'h8000, 64'h8000);
            end else begin
                push_exp(cur, n);
            end
            cur  = cur + n;
            left = left - n;
        end
    endtask

    task automatic send_seg(input logic [31:0] a, input logic [23:0] l, input bit last);
        @(posedge clk);
        seg_valid <= 1'b1;
        seg_addr  <= a;
        seg_len   <= l[LEN_W-1:0];
        seg_last  <= last;
        do @(negedge clk); while (!seg_ready);
        @(posedge clk);
        seg_valid <= 1'b0;
    endtask

    task automatic wait_done(input int base_d);
        for (int i = 0; i < 3000 && done_cnt == base_d; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_case(input int v);
        vec_t  t;
        int    base_c;
        int    base_d;
        int    got;
        string st_tag;
        string cnt_tag;
        string n_tag;
        t = VECS[v];
        exp_n = 0;
        model_seg(t.a0, t.l0);
        if (t.two) model_seg(t.a1, t.l1);
        case (t.st)
            2'd0:    st_tag = "R4";
            2'd1:    st_tag = "R6";
            2'd2:    st_tag = "R7";
            default: st_tag = "R8";
        endcase
        cnt_tag = (v == 2 || v == 3) ? "R3" : ((v == 5) ? "R5" : "R2");
        n_tag   = (v == 10) ? "R6" : ((v == 5) ? "R5" : "R1");

        base_c = cap_n;
        base_d = done_cnt;
        @(posedge clk);
        align_word <= t.al4;
        send_seg(t.a0, t.l0, !t.two);
        if (t.two) send_seg(t.a1, t.l1, 1'b1);
        wait_done(base_d);

        check(done_cnt == base_d + 1, (t.st != 2'd0) ? "R9" : "R4",
              $sformatf("vec%0d done pulses", v), 64'(done_cnt - base_d), 64'd1);
        check(got_status == t.st, st_tag, $sformatf("vec%0d status", v),
              64'(got_status), 64'(t.st));
        got = cap_n - base_c;
        check(got == int'(t.nd), n_tag, $sformatf("vec%0d descriptor count", v),
              64'(got), 64'(t.nd));
        for (int k = 0; k < int'(t.nd) && k < got; k++) begin
            logic [63:0] d;
            logic        exp_end;
            d = cap[(base_c + k) % 256];
            exp_end = (t.st == 2'd0) && (k == int'(t.nd) - 1);
            check(d[31:0] == exp_a[k], "R1", $sformatf("vec%0d desc%0d address", v, k),
                  64'(d[31:0]), 64'(exp_a[k]));
            check(d[47:32] == exp_c[k] && d[62:48] == 15'd0, cnt_tag,
                  $sformatf("vec%0d desc%0d count word", v, k),
                  64'(d[62:32]), 64'(exp_c[k]));
            check(d[63] == exp_end, "R4", $sformatf("vec%0d desc%0d end flag", v, k),
                  64'(d[63]), 64'(exp_end));
        end
    endtask

    task automatic run_all;
        int base_c;
        int base_d;

        // R11: reset state
        repeat (5) @(posedge clk);
        rst <= 1'b0;
        @(negedge clk);
        check(seg_ready == 1'b1, "R11", "seg_ready after reset", 64'(seg_ready), 64'd1);
        check(desc_valid == 1'b0, "R11", "desc_valid after reset", 64'(desc_valid), 64'd0);
        check(done_valid == 1'b0, "R11", "done_valid after reset", 64'(done_valid), 64'd0);

        // Vector table, free-running output then stalled output
        for (int pass = 0; pass < 2; pass++) begin
            @(posedge clk);
            stall <= (pass == 1);
            for (int v = 0; v < NVEC; v++) run_case(v);
        end

        // R10: descriptor held under backpressure
        @(posedge clk);
        stall     <= 1'b0;
        force_low <= 1'b1;
        align_word <= 1'b0;
        base_c = cap_n;
        base_d = done_cnt;
        send_seg(32'h0000_F000, 24'h03000, 1'b1);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(desc_valid == 1'b1, "R10", "valid held while stalled", 64'(desc_valid), 64'd1);
            check(desc_data == {1'b0, 15'd0, 16'h1000, 32'h0000_F000}, "R10",
                  "data held while stalled", desc_data, {1'b0, 15'd0, 16'h1000, 32'h0000_F000});
        end
        @(posedge clk);
        force_low <= 1'b0;
        wait_done(base_d);
        check(cap_n - base_c == 2, "R10", "descriptors after stall", 64'(cap_n - base_c), 64'd2);
        check(cap[(base_c + 1) % 256] == {1'b1, 15'd0, 16'h2000, 32'h0001_0000}, "R10",
              "second descriptor after stall", cap[(base_c + 1) % 256],
              {1'b1, 15'd0, 16'h2000, 32'h0001_0000});

        // R11: reset in the middle of a table
        @(posedge clk);
        force_low <= 1'b1;
        send_seg(32'h0000_0000, 24'h30000, 1'b1);
        repeat (4) @(negedge clk);
        @(posedge clk);
        rst <= 1'b1;
        @(posedge clk);
        rst <= 1'b0;
        force_low <= 1'b0;
        @(negedge clk);
        check(desc_valid == 1'b0, "R11", "desc_valid after mid-table reset", 64'(desc_valid), 64'd0);
        check(seg_ready == 1'b1, "R11", "seg_ready after mid-table reset", 64'(seg_ready), 64'd1);

        // A clean table right after the reset
        run_case(0);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            errors++;
            total++;
            $display("FAIL R4 watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

endmodule